// File: doc/BRIEF.md
# Indirect Register Window for an Ethernet Controller

This block is the register-access front end of an Ethernet controller. A host reaches it through a narrow 16-bit I/O window. It first loads a register number into a pointer port, then moves data through one of two data ports. One data port serves the control/status space and the other serves the bus-configuration space. Reading a dedicated reset port is enough to return the whole controller to its stopped state. No data needs to be written for that reset.

Control/status register 0 holds the run-control state machine. Write-one command bits request initialisation, start and an immediate transmit poll. A stop bit and an initialisation-done flag are the state that software can read back. The init-block fetch and the transmit poll are performed elsewhere. This block only issues one-cycle request strobes for them and accepts a completion strobe. Two read-only registers report a fixed identification word. Two configuration fields are brought out as level outputs: descriptor width and no-underflow buffering.

Top module: `nic_csr_window`

## Requirements
- R1: Byte offset 0x10 of the window is the control/status data port, 0x12 the pointer port, 0x14 the reset port and 0x16 the configuration data port. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: A read of the reset port returns 0. From the next cycle, all state is back at its reset value: CSR0 reads 0x0004 (only bit 2 set), the pointer is 0, storage registers hold their reset values and `running` is low.
- R3: The pointer keeps the low PTR_W bits (default 8) of the value written to it and reads them back zero-extended, so 88 reads back as 88.
- R4: Control/status register 88 reads the low half and register 89 the high half of a 32-bit identification word. Bits 11:0 of that word are 0x003, bits 27:12 are PART_CODE (default 0x2625) and bits 31:28 are 0. With the defaults, register 88 reads 0x5003 and register 89 reads 0x0262. Writes to these two registers are ignored.
- R5: A CSR0 write with bit 0 set and bit 2 clear raises `init_req` for exactly the next cycle and marks an initialisation as pending. `init_addr` always shows {CSR2, CSR1}. An `init_done` pulse while an initialisation is pending sets CSR0 bit 8 at the next edge. An `init_done` pulse with nothing pending is ignored.
- R6: A CSR0 write with bit 1 set and bit 2 clear clears CSR0 bit 2 and raises `running`. A CSR0 write with bit 3 set raises `poll_req` for one cycle, but only if the controller is running after that write.
- R7: CSR0 bits 0, 1 and 3 always read as 0. Writing 0 to them has no effect.
- R8: CSR0 bit 8 stays set until a CSR0 write with bit 8 set clears it, or until a reset or a stop. Writing 0 to bit 8 leaves it unchanged.
- R9: A CSR0 write with bit 2 set sets bit 2, drops `running`, cancels a pending initialisation and clears bit 8. In the same write, it overrides bits 0 and 1.
- R10: Implemented control/status registers are 0, 1, 2, 4, 80, 88 and 89. Implemented configuration registers are 2, 18, 20 and 32. Any other pointer value reads 0 in either space, and writes to it are ignored.
- R11: `desc32_mode` is high when bits 7:0 of configuration register 20 equal 2. `no_underflow` follows bit 11 of configuration register 18.
- R12: Control/status registers 1, 2, 4, 80 and all four configuration registers read back the last value written. Their reset values are 0, except configuration register 18, which resets to 0x9001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | Byte offset within the I/O window |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, valid in the same cycle as io_rd |
| init_done | input | 1 | Completion pulse from the init-block fetch |
| init_req | output | 1 | One-cycle request to fetch the init block |
| init_addr | output | 32 | Init-block address, {CSR2, CSR1} |
| poll_req | output | 1 | One-cycle request for an immediate transmit poll |
| running | output | 1 | High between a start command and a stop or reset |
| desc32_mode | output | 1 | 32-bit descriptor style selected |
| no_underflow | output | 1 | Whole-frame transmit buffering enabled |

## Verification
The pointer and the command state machine are the only state that software sees only indirectly. A corrupted pointer shows up as wrong data on the very next data-port read. An incorrect control state shows up on a missing or spurious `init_req` or `poll_req` in the cycle after the command write. It also shows up as a wrong CSR0 value on the following read. The soft-reset path is checked by reading every kind of register straight after the reset-port read. The storage banks are exercised with a random mix of implemented and unimplemented pointer values against a shadow model.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

   // Byte offsets of the four ports inside the I/O window
   localparam logic [4:0] OFS_CSR_DATA = 5'h10;
   localparam logic [4:0] OFS_POINTER  = 5'h12;
   localparam logic [4:0] OFS_SRESET   = 5'h14;
   localparam logic [4:0] OFS_BCR_DATA = 5'h16;

   // CSR0 bit positions (decoded by software, so they are fixed)
   localparam int C0_INIT = 0;
   localparam int C0_STRT = 1;
   localparam int C0_STOP = 2;
   localparam int C0_TDMD = 3;
   localparam int C0_IDON = 8;

   // Fixed register numbers
   localparam int IDX_CTRL   = 0;
   localparam int IDX_ID_LO  = 88;
   localparam int IDX_ID_HI  = 89;
   localparam int IDX_STYLE  = 20;
   localparam int IDX_BUFCFG = 18;
   localparam int BUFCFG_NOUF_BIT = 11;

   localparam logic [11:0] ID_LOW_TAG = 12'h003;
   localparam logic [7:0]  STYLE_32   = 8'd2;

   typedef enum logic [2:0] {
      PORT_NONE,
      PORT_CSR,
      PORT_PTR,
      PORT_RST,
      PORT_BCR
   } port_e;

endpackage

// File: rtl/nic_port_decode.sv
module nic_port_decode
   import nic_csr_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output port_e             port
);

   localparam int LOW_W = 5;

   generate
      if (ADDR_W < LOW_W) begin : g_bad_width
         $error("nic_port_decode: ADDR_W must cover the highest port offset");
      end
   endgenerate

   logic [LOW_W-1:0] low;
   logic             upper_clear;

   generate
      if (ADDR_W > LOW_W) begin : g_wide
         assign upper_clear = (addr[ADDR_W-1:LOW_W] == '0);
      end else begin : g_exact
         assign upper_clear = 1'b1;
      end
   endgenerate

   assign low = addr[LOW_W-1:0];

   always_comb begin
      port = PORT_NONE;
      if (upper_clear) begin
         unique case (low)
            OFS_CSR_DATA: port = PORT_CSR;
            OFS_POINTER:  port = PORT_PTR;
            OFS_SRESET:   port = PORT_RST;
            OFS_BCR_DATA: port = PORT_BCR;
            default:      port = PORT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank #(
   parameter int          N      = 4,
   parameter int          DW     = 16,
   parameter int          PTR_W  = 8,
   parameter int          IDX  [N] = '{default: 1},
   parameter logic [DW-1:0] RSTV [N] = '{default: '0}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [PTR_W-1:0]      ptr,
   input  logic                  wr_en,
   input  logic [DW-1:0]         wdata,
   output logic                  hit,
   output logic [DW-1:0]         rdata,
   output logic [N-1:0][DW-1:0]  q
);

   generate
      if (N < 1) begin : g_bad_n
         $error("nic_reg_bank: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] sel;

   for (genvar i = 0; i < N; i++) begin : g_reg
      assign sel[i] = (ptr == PTR_W'(IDX[i]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[i] <= RSTV[i];
         end else if (soft_rst) begin
            q[i] <= RSTV[i];
         end else if (wr_en && sel[i]) begin
            q[i] <= wdata;
         end
      end
   end

   assign hit = |sel;

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N; k++) begin
         if (sel[k]) rdata = rdata | q[k];
      end
   end

endmodule

// File: rtl/nic_ctrl0.sv
module nic_ctrl0
   import nic_csr_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          init_done,
   output logic [DW-1:0] value,
   output logic          init_req,
   output logic          poll_req,
   output logic          running
);

   generate
      if (DW <= C0_IDON) begin : g_bad_dw
         $error("nic_ctrl0: DW too narrow for the status bits");
      end
   endgenerate

   logic stop_q;
   logic idon_q;
   logic pend_q;
   logic run_q;

   logic cmd_stop, cmd_init, cmd_strt, cmd_tdmd, cmd_iack;
   logic run_after;

   assign cmd_stop = wr_en && wdata[C0_STOP];
   assign cmd_init = wr_en && wdata[C0_INIT] && !wdata[C0_STOP];
   assign cmd_strt = wr_en && wdata[C0_STRT] && !wdata[C0_STOP];
   assign cmd_tdmd = wr_en && wdata[C0_TDMD];
   assign cmd_iack = wr_en && wdata[C0_IDON];
   assign run_after = !cmd_stop && (run_q || cmd_strt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q   <= 1'b1;
         idon_q   <= 1'b0;
         pend_q   <= 1'b0;
         run_q    <= 1'b0;
         init_req <= 1'b0;
         poll_req <= 1'b0;
      end else if (soft_rst) begin
         stop_q   <= 1'b1;
         idon_q   <= 1'b0;
         pend_q   <= 1'b0;
         run_q    <= 1'b0;
         init_req <= 1'b0;
         poll_req <= 1'b0;
      end else begin
         init_req <= cmd_init;
         poll_req <= cmd_tdmd && run_after;
         // acknowledge first, so a completion in the same cycle wins
         if (cmd_iack) idon_q <= 1'b0;
         if (init_done && pend_q) begin
            idon_q <= 1'b1;
            pend_q <= 1'b0;
         end
         if (cmd_init) pend_q <= 1'b1;
         if (cmd_strt) begin
            run_q  <= 1'b1;
            stop_q <= 1'b0;
         end
         // stop overrides everything else in the same cycle
         if (cmd_stop) begin
            stop_q <= 1'b1;
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            idon_q <= 1'b0;
         end
      end
   end

   always_comb begin
      value          = '0;
      value[C0_STOP] = stop_q;
      value[C0_IDON] = idon_q;
   end

   assign running = run_q;

endmodule

// File: rtl/nic_csr_window.sv
module nic_csr_window
   import nic_csr_pkg::*;
#(
   parameter int          ADDR_W    = 5,
   parameter int          DW        = 16,
   parameter int          PTR_W     = 8,
   parameter logic [15:0] PART_CODE = 16'h2625,
   parameter logic [15:0] BCR18_RST = 16'h9001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DW-1:0]     io_wdata,
   output logic [DW-1:0]     io_rdata,
   input  logic              init_done,
   output logic              init_req,
   output logic [2*DW-1:0]   init_addr,
   output logic              poll_req,
   output logic              running,
   output logic              desc32_mode,
   output logic              no_underflow
);

   localparam int N_CSR = 4;
   localparam int N_BCR = 4;
   localparam int CSR_IDX [N_CSR] = '{1, 2, 4, 80};
   localparam int BCR_IDX [N_BCR] = '{2, 18, 20, 32};
   localparam logic [DW-1:0] CSR_RSTV [N_CSR] = '{default: '0};
   localparam logic [DW-1:0] BCR_RSTV [N_BCR] =
      '{DW'(0), DW'(BCR18_RST), DW'(0), DW'(0)};
   localparam int SLOT_ADDR_LO = 0;
   localparam int SLOT_ADDR_HI = 1;
   localparam int SLOT_BUFCFG  = 1;
   localparam int SLOT_STYLE   = 2;
   localparam logic [31:0] ID_WORD = {4'h0, PART_CODE, ID_LOW_TAG};

   generate
      if (DW != 16) begin : g_bad_dw
         $error("nic_csr_window: data ports are 16 bits wide");
      end
      if (PTR_W < 7 || PTR_W > DW) begin : g_bad_ptr
         $error("nic_csr_window: PTR_W must reach register 89 and fit a data word");
      end
   endgenerate

   port_e port;
   logic  soft_rst;
   logic  csr_wr, bcr_wr, ptr_wr;
   logic  ptr_is_ctrl, ptr_is_id_lo, ptr_is_id_hi;
   logic [PTR_W-1:0] ptr_q;

   logic                    csr_hit, bcr_hit;
   logic [DW-1:0]           csr_bank_rd, bcr_bank_rd, csr_rd, bcr_rd;
   logic [N_CSR-1:0][DW-1:0] csr_q;
   logic [N_BCR-1:0][DW-1:0] bcr_q;
   logic [DW-1:0]           csr0_val;

   nic_port_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (io_addr),
      .port (port)
   );

   assign soft_rst = io_rd && (port == PORT_RST);
   assign csr_wr   = io_wr && (port == PORT_CSR);
   assign bcr_wr   = io_wr && (port == PORT_BCR);
   assign ptr_wr   = io_wr && (port == PORT_PTR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (soft_rst) begin
         ptr_q <= '0;
      end else if (ptr_wr) begin
         ptr_q <= io_wdata[PTR_W-1:0];
      end
   end

   assign ptr_is_ctrl  = (ptr_q == PTR_W'(IDX_CTRL));
   assign ptr_is_id_lo = (ptr_q == PTR_W'(IDX_ID_LO));
   assign ptr_is_id_hi = (ptr_q == PTR_W'(IDX_ID_HI));

   nic_ctrl0 #(.DW(DW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .wr_en     (csr_wr && ptr_is_ctrl),
      .wdata     (io_wdata),
      .init_done (init_done),
      .value     (csr0_val),
      .init_req  (init_req),
      .poll_req  (poll_req),
      .running   (running)
   );

   nic_reg_bank #(
      .N(N_CSR), .DW(DW), .PTR_W(PTR_W), .IDX(CSR_IDX), .RSTV(CSR_RSTV)
   ) u_csr_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .ptr      (ptr_q),
      .wr_en    (csr_wr),
      .wdata    (io_wdata),
      .hit      (csr_hit),
      .rdata    (csr_bank_rd),
      .q        (csr_q)
   );

   nic_reg_bank #(
      .N(N_BCR), .DW(DW), .PTR_W(PTR_W), .IDX(BCR_IDX), .RSTV(BCR_RSTV)
   ) u_bcr_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .ptr      (ptr_q),
      .wr_en    (bcr_wr),
      .wdata    (io_wdata),
      .hit      (bcr_hit),
      .rdata    (bcr_bank_rd),
      .q        (bcr_q)
   );

   always_comb begin
      if (ptr_is_ctrl)       csr_rd = csr0_val;
      else if (ptr_is_id_lo) csr_rd = ID_WORD[15:0];
      else if (ptr_is_id_hi) csr_rd = ID_WORD[31:16];
      else if (csr_hit)      csr_rd = csr_bank_rd;
      else                   csr_rd = '0;
   end

   assign bcr_rd = bcr_hit ? bcr_bank_rd : '0;

   always_comb begin
      unique case (port)
         PORT_CSR: io_rdata = csr_rd;
         PORT_BCR: io_rdata = bcr_rd;
         PORT_PTR: io_rdata = DW'(ptr_q);
         default:  io_rdata = '0;
      endcase
   end

   assign init_addr    = {csr_q[SLOT_ADDR_HI], csr_q[SLOT_ADDR_LO]};
   assign desc32_mode  = (bcr_q[SLOT_STYLE][7:0] == STYLE_32);
   assign no_underflow = bcr_q[SLOT_BUFCFG][BUFCFG_NOUF_BIT];

   logic unused_bits;
   assign unused_bits = ^{csr_q[2], csr_q[3], bcr_q[0], bcr_q[3],
                          bcr_q[SLOT_STYLE][DW-1:8]};

endmodule

// File: rtl/nic_csr_window_chk.sv
module nic_csr_window_chk
   import nic_csr_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DW     = 16,
   parameter int PTR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DW-1:0]     io_wdata,
   input logic [DW-1:0]     io_rdata,
   input logic [PTR_W-1:0]  ptr_q,
   input logic [DW-1:0]     csr0_val,
   input logic              init_req,
   input logic              poll_req,
   input logic              running
);

   logic mapped, ctrl_wr;
   assign mapped  = (io_addr == ADDR_W'(OFS_CSR_DATA)) || (io_addr == ADDR_W'(OFS_POINTER)) ||
                    (io_addr == ADDR_W'(OFS_SRESET))   || (io_addr == ADDR_W'(OFS_BCR_DATA));
   assign ctrl_wr = io_wr && (io_addr == ADDR_W'(OFS_CSR_DATA)) && (ptr_q == '0);

   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !mapped) |-> (io_rdata == '0)); // R1

   AST_SRESET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == ADDR_W'(OFS_SRESET)) |=> (csr0_val == 16'h0004 && ptr_q == '0)); // R2

   AST_POINTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == ADDR_W'(OFS_POINTER)) |=> (ptr_q == $past(io_wdata[PTR_W-1:0]))); // R3

   AST_INIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && io_wdata[C0_INIT] && !io_wdata[C0_STOP]) |=> init_req); // R5

   AST_RUN_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> !csr0_val[C0_STOP]); // R6

   AST_POLL_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |-> running); // R6

   AST_STOP_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && io_wdata[C0_STOP]) |=> (csr0_val[C0_STOP] && !csr0_val[C0_IDON] && !running)); // R9

endmodule

bind nic_csr_window nic_csr_window_chk #(
   .ADDR_W(ADDR_W), .DW(DW), .PTR_W(PTR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_addr  (io_addr),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .io_wdata (io_wdata),
   .io_rdata (io_rdata),
   .ptr_q    (ptr_q),
   .csr0_val (csr0_val),
   .init_req (init_req),
   .poll_req (poll_req),
   .running  (running)
);

// File: tb/sim_nic_csr_window.sv
`timescale 1ns/1ps
module sim_nic_csr_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        init_done = 1'b0;
   logic        init_req;
   logic [31:0] init_addr;
   logic        poll_req;
   logic        running;
   logic        desc32_mode;
   logic        no_underflow;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   nic_csr_window u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .init_done(init_done),
      .init_req(init_req), .init_addr(init_addr), .poll_req(poll_req),
      .running(running), .desc32_mode(desc32_mode), .no_underflow(no_underflow)
   );

   // shadow of storage registers, indexed by register number
   logic [15:0] sh_csr [0:255];
   logic [15:0] sh_bcr [0:255];

   function automatic bit csr_store(int i);
      return i == 1 || i == 2 || i == 4 || i == 80;
   endfunction
   function automatic bit bcr_store(int i);
      return i == 2 || i == 18 || i == 20 || i == 32;
   endfunction
   function automatic logic [15:0] exp_csr(int i);
      if (i == 88) return 16'h5003;
      if (i == 89) return 16'h0262;
      if (csr_store(i)) return sh_csr[i];
      return 16'h0000;
   endfunction
   function automatic logic [15:0] exp_bcr(int i);
      return bcr_store(i) ? sh_bcr[i] : 16'h0000;
   endfunction

   task automatic shadow_reset();
      for (int i = 0; i < 256; i++) begin
         sh_csr[i] = 16'h0;
         sh_bcr[i] = 16'h0;
      end
      sh_bcr[18] = 16'h9001;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic io_write(logic [4:0] a, logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic csr_wr(int i, logic [15:0] d);
      io_write(5'h12, 16'(i));
      io_write(5'h10, d);
   endtask
   task automatic bcr_wr(int i, logic [15:0] d);
      io_write(5'h12, 16'(i));
      io_write(5'h16, d);
   endtask
   task automatic csr_rd(int i, output logic [15:0] d);
      io_write(5'h12, 16'(i));
      io_read(5'h10, d);
   endtask
   task automatic bcr_rd(int i, output logic [15:0] d);
      io_write(5'h12, 16'(i));
      io_read(5'h16, d);
   endtask

   task automatic pulse_done();
      @(negedge clk); init_done = 1'b1;
      @(negedge clk); init_done = 1'b0;
   endtask

   initial begin
      logic [15:0] v;
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      shadow_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      csr_rd(0, v);      check("R2 reset CSR0", v, 16'h0004);
      check("R2 reset running", running, 0);
      check("R11 reset no_underflow", no_underflow, 0);
      check("R11 reset desc32", desc32_mode, 0);

      // pointer readback
      io_write(5'h12, 16'd88); io_read(5'h12, v); check("R3 pointer 88", v, 16'd88);
      io_write(5'h12, 16'h1A5); io_read(5'h12, v); check("R3 pointer low bits", v, 16'h00A5);

      // identification
      csr_rd(88, v); check("R4 id low", v, 16'h5003);
      csr_rd(89, v); check("R4 id high", v, 16'h0262);
      csr_wr(88, 16'hFFFF); csr_rd(88, v); check("R4 id write ignored", v, 16'h5003);

      // unmapped offsets
      io_read(5'h00, v); check("R1 offset 0 reads zero", v, 0);
      io_read(5'h18, v); check("R1 offset 0x18 reads zero", v, 0);
      io_write(5'h12, 16'd80); io_write(5'h11, 16'hBEEF);
      io_read(5'h10, v); check("R1 odd offset write ignored", v, 0);

      // configuration outputs
      bcr_wr(20, 16'h0002); sh_bcr[20] = 16'h0002;
      check("R11 desc32 on", desc32_mode, 1);
      bcr_wr(18, 16'h0800); sh_bcr[18] = 16'h0800;
      check("R11 no_underflow on", no_underflow, 1);
      bcr_wr(20, 16'h0102); sh_bcr[20] = 16'h0102;
      check("R11 desc32 upper bits ignored", desc32_mode, 1);

      // init handshake
      csr_wr(1, 16'h1230); sh_csr[1] = 16'h1230;
      csr_wr(2, 16'h00AB); sh_csr[2] = 16'h00AB;
      check("R5 init_addr", init_addr, 32'h00AB1230);
      pulse_done();
      csr_rd(0, v); check("R5 stray done ignored", v, 16'h0004);
      csr_wr(0, 16'h0001);
      check("R5 init_req pulse", init_req, 1);
      @(negedge clk); check("R5 init_req one cycle", init_req, 0);
      io_read(5'h10, v); check("R7 command bits read zero", v, 16'h0004);
      pulse_done();
      io_read(5'h10, v); check("R5 IDON set", v, 16'h0104);
      io_write(5'h10, 16'h0000); io_read(5'h10, v); check("R8 write 0 keeps IDON", v, 16'h0104);
      io_write(5'h10, 16'h0100); io_read(5'h10, v); check("R8 IDON cleared", v, 16'h0004);

      // poll while stopped does nothing
      io_write(5'h10, 16'h0008);
      check("R6 no poll when stopped", poll_req, 0);
      // start
      io_write(5'h10, 16'h0002);
      check("R6 running", running, 1);
      io_read(5'h10, v); check("R6 STOP cleared", v, 16'h0000);
      io_write(5'h10, 16'h0008);
      check("R6 poll pulse", poll_req, 1);
      @(negedge clk); check("R6 poll one cycle", poll_req, 0);
      io_write(5'h10, 16'h0000);
      check("R7 zero write keeps running", running, 1);

      // stop overrides, after a fresh init completion
      io_write(5'h10, 16'h0001); pulse_done();
      io_write(5'h10, 16'h0007);
      check("R9 stop blocks init", init_req, 0);
      check("R9 stop drops running", running, 0);
      io_read(5'h10, v); check("R9 CSR0 after stop", v, 16'h0004);
      pulse_done();
      io_read(5'h10, v); check("R9 pending init cancelled", v, 16'h0004);

      // random storage traffic
      for (int it = 0; it < 300; it++) begin
         int idx;
         logic [15:0] d;
         idx = int'($urandom_range(1, 255));
         if (($urandom & 3) == 0) idx = (($urandom & 1) != 0) ? 18 : 80;
         d = 16'($urandom);
         case ($urandom_range(0, 3))
            0: begin csr_wr(idx, d); if (csr_store(idx)) sh_csr[idx] = d; end
            1: begin bcr_wr(idx, d); if (bcr_store(idx)) sh_bcr[idx] = d; end
            2: begin csr_rd(idx, v);
                  check(csr_store(idx) ? "R12 csr readback" : "R10 csr unimplemented", v, exp_csr(idx)); end
            default: begin bcr_rd(idx, v);
                  check(bcr_store(idx) ? "R12 bcr readback" : "R10 bcr unimplemented", v, exp_bcr(idx)); end
         endcase
      end
      check("R11 no_underflow tracks", no_underflow, sh_bcr[18][11]);

      // soft reset
      csr_wr(4, 16'h5A5A); io_write(5'h10, 16'h0000);
      csr_wr(0, 16'h0002);
      io_read(5'h14, v); check("R2 reset port reads zero", v, 0);
      check("R2 running cleared", running, 0);
      shadow_reset();
      io_read(5'h12, v); check("R2 pointer cleared", v, 0);
      io_read(5'h10, v); check("R2 CSR0 after soft reset", v, 16'h0004);
      csr_rd(4, v); check("R2 CSR4 cleared", v, 0);
      bcr_rd(18, v); check("R2 BCR18 reset value", v, 16'h9001);
      check("R2 init_addr cleared", init_addr, 0);

      done = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule